// File: doc/BRIEF.md
# Full-Map Directory Coherence Controller

This block is the home-node directory for a write-back, write-invalidate coherence scheme shared by a parameterised number of caching agents. For every memory block it stores a presence vector with one bit per agent and a single dirty flag. A set dirty flag names exactly one agent as the owner of a modified copy. Agents present read misses and write misses on the request channel. The controller then sends recall or invalidate messages to the affected agents, gathers their acknowledgements or written-back data, refreshes its small backing store, and grants the line to the requester.

The controller takes one request at a time, so a second request to the same block waits until the first has been granted. A recalled owner writes its data back before the requester is served. A write miss on a shared block invalidates all other sharers in the same cycle, and it is granted only after every one of them has acknowledged.

Top module: `fullmap_dir_ctrl`

## Requirements
- R1: After reset every directory entry has an all-zero presence vector and a clear dirty flag, every memory word is zero, reqReady is high, and msgValid and grantValid are low.
- R2: Whenever a block's dirty flag is set, its presence vector has exactly one bit set, so a recall is always sent to one agent only.
- R3: A read miss on a clean block is granted from memory with grantExcl low and without any message. The requester's presence bit is added, and the existing sharers are kept.
- R4: A read miss on a block owned by another agent sends msgKind 1 (recall, keep shared) to the owner alone. The owner's data response is written to memory and returned in the grant. The block becomes clean, with presence bits for the owner and the requester.
- R5: A write miss on a clean block sends msgKind 3 (invalidate), in a single cycle, to every present agent other than the requester. grantValid stays low until an acknowledgement (rspIsData low) has arrived from each of them. The block then becomes dirty, with only the requester present.
- R6: A write miss on a block owned by another agent sends msgKind 2 (recall, invalidate) to the owner alone. Its data response updates memory and is granted exclusively. The block becomes dirty, with only the requester present.
- R7: A response is ignored when it comes from an agent that is not being waited on or carries the wrong kind (data while acknowledgements are awaited, or an acknowledgement while data is awaited). Such a response does not alter memory or the pending set.
- R8: reqReady goes low in the cycle after a request is accepted. It stays low until the grant cycle has passed, so only one transaction is ever in flight.
- R9: A miss from the agent that already owns a dirty block sends no message and is served from memory. A read leaves the block clean with only that agent present. A write leaves it dirty with only that agent present.
- R10: A write miss on a block that no other agent holds is granted exclusively without any message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Miss request present |
| reqReady | output | 1 | Controller idle and accepting |
| reqAgent | input | AGENT_W | Requesting agent index |
| reqWrite | input | 1 | 1 = write miss, 0 = read miss |
| reqBlock | input | BLK_W | Block index |
| msgValid | output | AGENTS | One bit per destination agent |
| msgKind | output | 2 | 1 recall-shared, 2 recall-invalidate, 3 invalidate |
| msgBlock | output | BLK_W | Block the message refers to |
| rspValid | input | 1 | Response from an agent present |
| rspAgent | input | AGENT_W | Responding agent |
| rspIsData | input | 1 | 1 = writeback data, 0 = invalidate acknowledgement |
| rspData | input | DATA_W | Writeback data |
| grantValid | output | 1 | Grant to requester this cycle |
| grantAgent | output | AGENT_W | Agent being granted |
| grantExcl | output | 1 | Grant is exclusive (write miss) |
| grantBlock | output | BLK_W | Granted block |
| grantData | output | DATA_W | Line data from memory |

## Verification
The bench drives a sequence of misses on one block so that the block passes through every directory condition: clean with no sharers, clean with several sharers, and dirty with the owner either differing from or equal to the requester. Each step is told apart by the message kind and destination mask, which reveal the directory state left by the step before. Stray responses are injected ahead of the real acknowledgements and writebacks, to separate correct response matching from merely counting responses. A second reset followed by a read of a previously written block shows that both the entries and the memory were cleared.

// File: rtl/fmdir_pkg.sv
package fmdir_pkg;

  typedef enum logic [1:0] {
    MSG_NONE         = 2'd0,
    MSG_RECALL_SHARE = 2'd1,
    MSG_RECALL_INVAL = 2'd2,
    MSG_INVAL        = 2'd3
  } msg_kind_e;

  typedef struct packed {
    logic latchReq;
    logic sendRecall;
    logic sendInval;
    logic loadPending;
    logic takeAck;
    logic takeWb;
    logic commit;
  } dp_ctrl_t;

endpackage

// File: rtl/fmdir_datapath.sv
module fmdir_datapath
  import fmdir_pkg::*;
#(
  parameter int AGENTS  = 4,
  parameter int BLOCKS  = 8,
  parameter int DATA_W  = 32,
  parameter int AGENT_W = 2,
  parameter int BLK_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  dp_ctrl_t           ctrl,
  input  logic [AGENT_W-1:0] reqAgent,
  input  logic               reqWrite,
  input  logic [BLK_W-1:0]   reqBlock,
  input  logic               rspValid,
  input  logic [AGENT_W-1:0] rspAgent,
  input  logic               rspIsData,
  input  logic [DATA_W-1:0]  rspData,
  output logic               needRecall,
  output logic               invNeeded,
  output logic               pendingZero,
  output logic               wbHit,
  output logic               curWrite,
  output logic [AGENTS-1:0]  msgValid,
  output logic [1:0]         msgKind,
  output logic [BLK_W-1:0]   msgBlock,
  output logic [AGENT_W-1:0] grantAgent,
  output logic               grantExcl,
  output logic [BLK_W-1:0]   grantBlock,
  output logic [DATA_W-1:0]  grantData
);

  logic [AGENTS-1:0] presArr [BLOCKS];
  logic [BLOCKS-1:0] dirtyArr;
  logic [DATA_W-1:0] memArr  [BLOCKS];

  logic [AGENT_W-1:0] curAgent;
  logic [BLK_W-1:0]   curBlk;
  logic               curWr;
  logic [AGENTS-1:0]  pending;

  logic [AGENTS-1:0] curPres;
  logic              curDirty;
  logic [AGENTS-1:0] reqMask;
  logic [AGENTS-1:0] rspMask;
  logic [AGENTS-1:0] othersMask;
  logic [AGENTS-1:0] nextPres;
  logic              ackHit;
  logic [BLOCKS-1:0] commitWe;
  logic [BLOCKS-1:0] wbWe;

  always_comb begin
    curPres  = presArr[curBlk];
    curDirty = dirtyArr[curBlk];
    reqMask  = '0;
    reqMask[curAgent] = 1'b1;
    rspMask  = '0;
    rspMask[rspAgent] = 1'b1;
    othersMask = curPres & ~reqMask;
    nextPres   = curWr ? reqMask : (curPres | reqMask);
  end

  assign needRecall  = curDirty && (othersMask != '0);
  assign invNeeded   = (othersMask != '0);
  assign pendingZero = (pending == '0);
  assign wbHit       = rspValid && rspIsData && ((othersMask & rspMask) != '0);
  assign ackHit      = rspValid && !rspIsData && ((pending & rspMask) != '0);
  assign curWrite    = curWr;

  // per-block write enables
  for (genvar b = 0; b < BLOCKS; b++) begin : g_blockWe
    assign commitWe[b] = ctrl.commit && (curBlk == BLK_W'(b));
    assign wbWe[b]     = ctrl.takeWb && wbHit && (curBlk == BLK_W'(b));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < BLOCKS; b++) begin
        presArr[b] <= '0;
        memArr[b]  <= '0;
      end
      dirtyArr <= '0;
    end else begin
      for (int b = 0; b < BLOCKS; b++) begin
        if (commitWe[b]) begin
          presArr[b]  <= nextPres;
          dirtyArr[b] <= curWr;
        end
        if (wbWe[b]) memArr[b] <= rspData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAgent <= '0;
      curBlk   <= '0;
      curWr    <= 1'b0;
      pending  <= '0;
    end else begin
      if (ctrl.latchReq) begin
        curAgent <= reqAgent;
        curBlk   <= reqBlock;
        curWr    <= reqWrite;
      end
      if (ctrl.loadPending) pending <= othersMask;
      else if (ctrl.takeAck && ackHit) pending <= pending & ~rspMask;
    end
  end

  always_comb begin
    msgValid = '0;
    msgKind  = MSG_NONE;
    if (ctrl.sendRecall) begin
      msgValid = othersMask;
      msgKind  = curWr ? MSG_RECALL_INVAL : MSG_RECALL_SHARE;
    end else if (ctrl.sendInval) begin
      msgValid = othersMask;
      msgKind  = MSG_INVAL;
    end
  end

  assign msgBlock   = curBlk;
  assign grantAgent = curAgent;
  assign grantExcl  = curWr;
  assign grantBlock = curBlk;
  assign grantData  = memArr[curBlk];

  // R2: a dirty entry never names more than one holder
  a_r2_dirty_single: assert property (@(posedge clk) disable iff (!rstN)
    curDirty |-> $onehot(curPres));

  // R4 / R6: a recall goes to exactly one agent
  a_r4_recall_one_target: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.sendRecall |-> $onehot(msgValid));

  // R5: commit only once every invalidated sharer has acknowledged
  a_r5_grant_after_acks: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.commit |-> (pending == '0));

  // R7: responses outside an accepted ack leave the pending set as it was
  a_r7_pending_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.loadPending && !(ctrl.takeAck && ackHit)) |=> $stable(pending));

endmodule

// File: rtl/fmdir_control.sv
module fmdir_control
  import fmdir_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     needRecall,
  input  logic     invNeeded,
  input  logic     pendingZero,
  input  logic     wbHit,
  input  logic     curWrite,
  output logic     reqReady,
  output logic     grantValid,
  output dp_ctrl_t ctrl
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_WAIT_WB, ST_WAIT_ACK, ST_GRANT
  } state_e;

  state_e state, stateNext;

  always_comb begin
    stateNext  = state;
    ctrl       = '0;
    reqReady   = 1'b0;
    grantValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctrl.latchReq = 1'b1;
          stateNext     = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (needRecall) begin
          ctrl.sendRecall = 1'b1;
          stateNext       = ST_WAIT_WB;
        end else if (curWrite && invNeeded) begin
          ctrl.sendInval   = 1'b1;
          ctrl.loadPending = 1'b1;
          stateNext        = ST_WAIT_ACK;
        end else begin
          stateNext = ST_GRANT;
        end
      end
      ST_WAIT_WB: begin
        ctrl.takeWb = 1'b1;
        if (wbHit) stateNext = ST_GRANT;
      end
      ST_WAIT_ACK: begin
        ctrl.takeAck = 1'b1;
        if (pendingZero) stateNext = ST_GRANT;
      end
      ST_GRANT: begin
        grantValid  = 1'b1;
        ctrl.commit = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R8: after an accepted request the channel closes
  a_r8_one_in_flight: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R8: the channel reopens right after the grant
  a_r8_ready_after_grant: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |=> reqReady);

  // R4 / R6: a writeback wait ends only in a grant
  a_r6_wb_then_grant: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_WB && wbHit) |=> grantValid);

endmodule

// File: rtl/fullmap_dir_ctrl.sv
module fullmap_dir_ctrl
  import fmdir_pkg::*;
#(
  parameter int AGENTS = 4,
  parameter int BLOCKS = 8,
  parameter int DATA_W = 32,
  localparam int AGENT_W = $clog2(AGENTS),
  localparam int BLK_W   = $clog2(BLOCKS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [AGENT_W-1:0] reqAgent,
  input  logic               reqWrite,
  input  logic [BLK_W-1:0]   reqBlock,
  output logic [AGENTS-1:0]  msgValid,
  output logic [1:0]         msgKind,
  output logic [BLK_W-1:0]   msgBlock,
  input  logic               rspValid,
  input  logic [AGENT_W-1:0] rspAgent,
  input  logic               rspIsData,
  input  logic [DATA_W-1:0]  rspData,
  output logic               grantValid,
  output logic [AGENT_W-1:0] grantAgent,
  output logic               grantExcl,
  output logic [BLK_W-1:0]   grantBlock,
  output logic [DATA_W-1:0]  grantData
);

  dp_ctrl_t ctrl;
  logic needRecall, invNeeded, pendingZero, wbHit, curWrite;

  fmdir_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .needRecall (needRecall),
    .invNeeded  (invNeeded),
    .pendingZero(pendingZero),
    .wbHit      (wbHit),
    .curWrite   (curWrite),
    .reqReady   (reqReady),
    .grantValid (grantValid),
    .ctrl       (ctrl)
  );

  fmdir_datapath #(
    .AGENTS (AGENTS),
    .BLOCKS (BLOCKS),
    .DATA_W (DATA_W),
    .AGENT_W(AGENT_W),
    .BLK_W  (BLK_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .reqAgent   (reqAgent),
    .reqWrite   (reqWrite),
    .reqBlock   (reqBlock),
    .rspValid   (rspValid),
    .rspAgent   (rspAgent),
    .rspIsData  (rspIsData),
    .rspData    (rspData),
    .needRecall (needRecall),
    .invNeeded  (invNeeded),
    .pendingZero(pendingZero),
    .wbHit      (wbHit),
    .curWrite   (curWrite),
    .msgValid   (msgValid),
    .msgKind    (msgKind),
    .msgBlock   (msgBlock),
    .grantAgent (grantAgent),
    .grantExcl  (grantExcl),
    .grantBlock (grantBlock),
    .grantData  (grantData)
  );

endmodule

// File: tb/test_fullmap_dir_ctrl.sv
`timescale 1ns/1ps
module test_fullmap_dir_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqAgent = '0;
  logic        reqWrite = 1'b0;
  logic [2:0]  reqBlock = '0;
  logic [3:0]  msgValid;
  logic [1:0]  msgKind;
  logic [2:0]  msgBlock;
  logic        rspValid = 1'b0;
  logic [1:0]  rspAgent = '0;
  logic        rspIsData = 1'b0;
  logic [31:0] rspData = '0;
  logic        grantValid;
  logic [1:0]  grantAgent;
  logic        grantExcl;
  logic [2:0]  grantBlock;
  logic [31:0] grantData;

  always #2 clk = ~clk;

  fullmap_dir_ctrl i_fullmap_dir_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAgent(reqAgent),
    .reqWrite(reqWrite), .reqBlock(reqBlock),
    .msgValid(msgValid), .msgKind(msgKind), .msgBlock(msgBlock),
    .rspValid(rspValid), .rspAgent(rspAgent), .rspIsData(rspIsData), .rspData(rspData),
    .grantValid(grantValid), .grantAgent(grantAgent), .grantExcl(grantExcl),
    .grantBlock(grantBlock), .grantData(grantData)
  );

  int checks = 0;
  int failures = 0;
  logic [31:0] modelMem [8];

  typedef struct packed {
    logic [1:0] agent;
    logic       wr;
    logic [2:0] blk;
    logic [1:0] kind;
    logic [3:0] mask;
    logic       own;
  } vec_t;

  // agent, write, block, expected kind, expected mask, owner-request flag
  localparam vec_t VECS [15] = '{
    '{2'd0, 1'b0, 3'd1, 2'd0, 4'b0000, 1'b0},
    '{2'd1, 1'b0, 3'd1, 2'd0, 4'b0000, 1'b0},
    '{2'd2, 1'b0, 3'd1, 2'd0, 4'b0000, 1'b0},
    '{2'd3, 1'b1, 3'd1, 2'd3, 4'b0111, 1'b0},
    '{2'd0, 1'b0, 3'd1, 2'd1, 4'b1000, 1'b0},
    '{2'd1, 1'b1, 3'd1, 2'd3, 4'b1001, 1'b0},
    '{2'd2, 1'b1, 3'd1, 2'd2, 4'b0010, 1'b0},
    '{2'd2, 1'b0, 3'd1, 2'd0, 4'b0000, 1'b1},
    '{2'd2, 1'b1, 3'd1, 2'd0, 4'b0000, 1'b1},
    '{2'd0, 1'b1, 3'd2, 2'd0, 4'b0000, 1'b0},
    '{2'd3, 1'b0, 3'd2, 2'd1, 4'b0001, 1'b0},
    '{2'd1, 1'b0, 3'd1, 2'd1, 4'b0100, 1'b0},
    '{2'd0, 1'b1, 3'd1, 2'd3, 4'b0110, 1'b0},
    '{2'd0, 1'b1, 3'd1, 2'd0, 4'b0000, 1'b1},
    '{2'd3, 1'b0, 3'd1, 2'd1, 4'b0001, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(input vec_t v);
    if (v.own) return "R9";
    case (v.kind)
      2'd1: return "R4";
      2'd2: return "R6";
      2'd3: return "R5";
      default: return v.wr ? "R10" : "R3";
    endcase
  endfunction

  task automatic runReq(input vec_t v, input string tag, input int idx);
    int owner = 0;
    @(negedge clk);
    check(reqReady == 1'b1, "R8", "ready while idle", reqReady, 1);
    reqValid = 1'b1; reqAgent = v.agent; reqWrite = v.wr; reqBlock = v.blk;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R8", "ready during transaction", reqReady, 0);
    check(msgValid == v.mask, tag, "message mask", msgValid, v.mask);
    if (v.mask != 4'b0000) begin
      check(msgKind == v.kind, tag, "message kind", msgKind, v.kind);
      check(msgBlock == v.blk, tag, "message block", msgBlock, v.blk);
    end
    if (v.kind == 2'd3) begin
      @(negedge clk);
      rspValid = 1'b1; rspAgent = v.agent; rspIsData = 1'b0; // R7 stray ack
      for (int a = 0; a < 4; a++) begin
        if (v.mask[a]) begin
          @(negedge clk);
          check(grantValid == 1'b0, "R5", "grant before all acks", grantValid, 0);
          rspValid = 1'b1; rspAgent = 2'(a); rspIsData = 1'b0;
        end
      end
      @(negedge clk);
      rspValid = 1'b0;
    end else if (v.kind == 2'd1 || v.kind == 2'd2) begin
      for (int a = 0; a < 4; a++) if (v.mask[a]) owner = a;
      @(negedge clk);
      rspValid = 1'b1; rspAgent = v.agent; rspIsData = 1'b1; // R7 stray data
      rspData = 32'hDEAD_0000 + 32'(idx);
      @(negedge clk);
      rspAgent = 2'(owner); rspIsData = 1'b0; // R7 ack where data is due
      @(negedge clk);
      check(grantValid == 1'b0, "R7", "grant after stray responses", grantValid, 0);
      rspAgent = 2'(owner); rspIsData = 1'b1;
      rspData = 32'hC0DE_0000 + 32'(idx);
      modelMem[v.blk] = rspData;
      @(negedge clk);
      rspValid = 1'b0;
    end
    for (int t = 0; t < 20 && !grantValid; t++) @(negedge clk);
    check(grantValid == 1'b1, tag, "grant seen", grantValid, 1);
    check(grantAgent == v.agent, tag, "grant agent", grantAgent, v.agent);
    check(grantExcl == v.wr, tag, "grant exclusive", grantExcl, v.wr);
    check(grantBlock == v.blk, tag, "grant block", grantBlock, v.blk);
    check(grantData == modelMem[v.blk], tag, "grant data", grantData, modelMem[v.blk]);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<50000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    for (int b = 0; b < 8; b++) modelMem[b] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(reqReady == 1'b1, "R1", "ready after reset", reqReady, 1);
    check(msgValid == 4'b0, "R1", "no messages after reset", msgValid, 0);
    check(grantValid == 1'b0, "R1", "no grant after reset", grantValid, 0);
    rstN = 1'b1;

    for (int i = 0; i < 15; i++) runReq(VECS[i], tagOf(VECS[i]), i);

    // R2: a dirty block recalls from a single holder
    runReq('{2'd1, 1'b1, 3'd3, 2'd0, 4'b0000, 1'b0}, "R10", 20);
    runReq('{2'd0, 1'b1, 3'd3, 2'd2, 4'b0010, 1'b0}, "R2", 21);

    // R1: reset clears entries and memory
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "ready in reset", reqReady, 1);
    rstN = 1'b1;
    for (int b = 0; b < 8; b++) modelMem[b] = '0;
    runReq('{2'd2, 1'b0, 3'd1, 2'd0, 4'b0000, 1'b0}, "R1", 30);
    runReq('{2'd1, 1'b1, 3'd3, 2'd0, 4'b0000, 1'b0}, "R1", 31);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule